// File: doc/BRIEF.md
# I2C Slave Clock Stretch Controller

This block decides when an I2C/SMBus slave may hold the serial clock low to buy itself time, and for how long. It samples both bus lines through synchronizers, recognises START and STOP conditions, and counts clock pulses within each byte so that it knows when the acknowledge clock has finished. When the slave's internal logic raises its busy input, the block holds SCL low only at a legal point. A legal point is the falling clock edge that follows a START (including a repeated START), or the falling edge that ends the ninth (acknowledge) clock of a byte.

The block never produces clock pulses and never drives a line high. Its only bus output is an enable for an open-drain pull-down on SCL. The pull is released as soon as busy drops. It is also released unconditionally once a stretch has lasted 25 ms, counted in system clock cycles derived from a clock-frequency parameter. When that cap is hit, a sticky timeout flag is raised and stays set until reset. Address matching, data shifting and error checking belong to neighbouring logic.

Top module: `scl_stretch_ctrl`

## Requirements
- R1: After reset, `scl_pull_o` and `timeout_o` are both low.
- R2: If `busy_i` is high when SCL falls for the first time after a START, SCL is pulled low, with `scl_pull_o` asserted three system clocks after the SCL fall at the pin.
- R3: If `busy_i` is high when SCL falls at the end of the ninth clock of a byte, SCL is pulled low.
- R4: Busy asserted during clocks one to eight of a byte does not pull SCL at those clocks' falling edges. The request waits for the next legal point.
- R5: While stretching, the pull is released on the clock after `busy_i` is sampled low.
- R6: One stretch lasts at most LIMIT = CLK_HZ/1000*STRETCH_MS system clocks even if busy stays high. When the cap ends a stretch, `timeout_o` is set.
- R7: `timeout_o` stays set until reset, and later legal points still stretch normally.
- R8: After a STOP, SCL falling edges do not cause stretching until the next START.
- R9: A repeated START in the middle of a byte restarts the clock count. Its following fall is a legal point, and the acknowledge point comes nine clocks later.
- R10: With `busy_i` low at a legal point, SCL is not pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pin |
| sda_i | input | 1 | SDA line level as seen at the pin |
| busy_i | input | 1 | Slave logic not ready for the next transfer |
| scl_pull_o | output | 1 | Enable for the open-drain pull-down on SCL |
| timeout_o | output | 1 | Sticky: a stretch was cut off at the cap |

## Verification
The bench builds the block with CLK_HZ = 2000 and STRETCH_MS = 25, which puts the stretch cap at 50 system clocks. At that size, a stretch held by a busy input that never drops runs all the way to its forced release in a short run. This lets the bench measure the exact cap length and then confirm the sticky flag. The I2C clock phase is eight system clocks, which keeps every bit count, repeated START and STOP sequence cheap to exercise.

// File: rtl/scl_stretch_pkg.sv
package scl_stretch_pkg;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

endpackage

// File: rtl/scl_sync2.sv
module scl_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= d_i[g];
                stab_q <= meta_q;
            end
        end
        assign q_o[g] = stab_q;
    end
endmodule

// File: rtl/scl_bus_events.sv
module scl_bus_events
    import scl_stretch_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev_o
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    always_comb begin
        ev_o.rise  = scl_s && !scl_prev_q;
        ev_o.fall  = !scl_s && scl_prev_q;
        ev_o.start = scl_s && scl_prev_q && sda_prev_q && !sda_s;
        ev_o.stop  = scl_s && scl_prev_q && !sda_prev_q && sda_s;
    end
endmodule

// File: rtl/scl_stretch_timer.sv
module scl_stretch_timer #(
    parameter int LIMIT = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = run_i ? cnt_q + 1'b1 : '0;
        expired_o = run_i && (cnt_q == TW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scl_stretch_ctrl.sv
module scl_stretch_ctrl
    import scl_stretch_pkg::*;
#(
    parameter int CLK_HZ     = 50000000,
    parameter int STRETCH_MS = 25,
    parameter int FRAME_BITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic busy_i,
    output logic scl_pull_o,
    output logic timeout_o
);
    localparam int LIMIT = (CLK_HZ / 1000) * STRETCH_MS;
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic             in_frame;
        logic [CNT_W-1:0] bit_cnt;
        logic             stretch;
        logic             timeout;
    } ctrl_t;

    logic [1:0] line_s;
    logic       scl_s;
    logic       sda_s;
    bus_ev_t    ev;
    logic       expired;
    logic       legal_point;
    ctrl_t      st_d, st_q;

    scl_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (line_s)
    );
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    scl_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev_o  (ev)
    );

    scl_stretch_timer #(.LIMIT(LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.stretch),
        .expired_o (expired)
    );

    // A fall is legal right after a START (count 0) or after the ACK clock.
    assign legal_point = ev.fall && st_q.in_frame &&
                         ((st_q.bit_cnt == '0) ||
                          (st_q.bit_cnt == CNT_W'(FRAME_BITS)));

    always_comb begin
        st_d = st_q;
        if (ev.start) begin
            st_d.in_frame = 1'b1;
            st_d.bit_cnt  = '0;
        end else if (ev.stop) begin
            st_d.in_frame = 1'b0;
            st_d.bit_cnt  = '0;
        end else if (ev.rise && st_q.in_frame) begin
            if (st_q.bit_cnt == CNT_W'(FRAME_BITS)) st_d.bit_cnt = CNT_W'(1);
            else                                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
        end

        if (st_q.stretch) begin
            if (!busy_i || expired) st_d.stretch = 1'b0;
            if (expired)            st_d.timeout = 1'b1;
        end else if (legal_point && busy_i) begin
            st_d.stretch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scl_pull_o = st_q.stretch;
    assign timeout_o  = st_q.timeout;
endmodule

// File: rtl/scl_stretch_ctrl_checker.sv
module scl_stretch_ctrl_checker #(
    parameter int LIMIT = 1250000
) (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic scl_s,
    input logic scl_pull_o,
    input logic timeout_o
);
    localparam int HW = $clog2(LIMIT + 2);
    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold_cnt <= '0;
        else if (scl_pull_o) hold_cnt <= (hold_cnt == HW'(LIMIT + 1)) ? hold_cnt : hold_cnt + 1'b1;
        else                 hold_cnt <= '0;
    end

    assert_pull_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_o) |-> $past(busy_i));

    assert_pull_while_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_o) |-> !$past(scl_s));

    assert_release_on_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull_o && !busy_i) |=> !scl_pull_o);

    assert_stretch_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HW'(LIMIT));

    assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(scl_pull_o));

    assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> timeout_o);
endmodule

bind scl_stretch_ctrl scl_stretch_ctrl_checker #(.LIMIT(LIMIT)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .scl_s      (scl_s),
    .scl_pull_o (scl_pull_o),
    .timeout_o  (timeout_o)
);

// File: tb/scl_stretch_ctrl_tb_top.sv
module scl_stretch_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  CLK_HZ     = 2000;
    localparam int  STRETCH_MS = 25;
    localparam int  LIMIT      = (CLK_HZ / 1000) * STRETCH_MS;
    localparam int  HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic scl_pull, timeout;
    logic scl_line;
    logic last_pull;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign scl_line = scl_m & ~scl_pull;

    scl_stretch_ctrl #(.CLK_HZ(CLK_HZ), .STRETCH_MS(STRETCH_MS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_line),
        .sda_i      (sda_m),
        .busy_i     (busy),
        .scl_pull_o (scl_pull),
        .timeout_o  (timeout)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic release_scl();
        scl_m = 1'b1;
        for (int i = 0; i < 400 && !scl_line; i++) wait_clk(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        release_scl();
        wait_clk(HALF);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(HALF);
        last_pull = scl_pull;
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b;
        wait_clk(HALF / 2);
        release_scl();
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(HALF);
        last_pull = scl_pull;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(HALF / 2);
        release_scl();
        wait_clk(HALF);
        sda_m = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic test_reset();
        check("R1 pull", scl_pull, 1'b0);
        check("R1 timeout", timeout, 1'b0);
    endtask

    task automatic test_idle_and_ack();
        bus_start();
        check("R10 no busy at start point", last_pull, 1'b0);
        for (int i = 1; i <= 8; i++) begin
            if (i == 3) busy = 1'b1;
            bus_bit(i[0]);
            check("R4 busy mid-byte", last_pull, 1'b0);
        end
        bus_bit(1'b0);
        check("R3 stretch after ack", last_pull, 1'b1);
        wait_clk(5);
        busy = 1'b0;
        wait_clk(1);
        check("R5 release after ready", scl_pull, 1'b0);
        check("R6 no timeout on short stretch", timeout, 1'b0);
        for (int i = 1; i <= 9; i++) begin
            bus_bit(1'b1);
            check("R10 no busy at ack", last_pull, 1'b0);
        end
        bus_stop();
    endtask

    task automatic test_start_stretch();
        busy = 1'b1;
        sda_m = 1'b1;
        release_scl();
        wait_clk(HALF);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(2);
        check("R2 not before 3 clocks", scl_pull, 1'b0);
        wait_clk(1);
        check("R2 pull after start fall", scl_pull, 1'b1);
        wait_clk(4);
        busy = 1'b0;
        wait_clk(1);
        check("R5 release after start stretch", scl_pull, 1'b0);
        bus_bit(1'b1);
        bus_stop();
    endtask

    task automatic test_after_stop();
        busy = 1'b1;
        scl_m = 1'b0;
        wait_clk(HALF);
        check("R8 no stretch outside frame", scl_pull, 1'b0);
        release_scl();
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(HALF);
        check("R8 no stretch second fall", scl_pull, 1'b0);
        busy = 1'b0;
        release_scl();
        wait_clk(HALF);
    endtask

    task automatic test_repeated_start();
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        busy = 1'b1;
        sda_m = 1'b1;
        wait_clk(HALF / 2);
        release_scl();
        wait_clk(HALF);
        sda_m = 1'b0;
        wait_clk(HALF);
        scl_m = 1'b0;
        wait_clk(HALF);
        check("R9 stretch after repeated start", scl_pull, 1'b1);
        busy = 1'b0;
        wait_clk(2);
        busy = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            bus_bit(1'b0);
            check("R9 count restarted", last_pull, 1'b0);
        end
        bus_bit(1'b0);
        check("R9 ack point moved", last_pull, 1'b1);
        busy = 1'b0;
        wait_clk(2);
        bus_stop();
    endtask

    task automatic test_timeout();
        int len;
        bus_start();
        busy = 1'b1;
        for (int i = 1; i <= 9; i++) bus_bit(1'b1);
        len = 0;
        for (int i = 0; i < 400 && scl_pull; i++) begin
            len++;
            wait_clk(1);
        end
        len = len + HALF - 3;
        n_checks++;
        if (len != LIMIT) begin
            n_fail++;
            $display("FAIL R6 stretch length: actual %0d expected %0d", len, LIMIT);
        end
        check("R6 timeout set", timeout, 1'b1);
        check("R6 released with busy high", scl_pull, 1'b0);
        busy = 1'b0;
        for (int i = 1; i <= 8; i++) bus_bit(1'b1);
        busy = 1'b1;
        bus_bit(1'b0);
        check("R7 later ack still stretches", last_pull, 1'b1);
        busy = 1'b0;
        wait_clk(2);
        check("R7 timeout sticky", timeout, 1'b1);
        bus_stop();
        check("R7 sticky after stop", timeout, 1'b1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        wait_clk(3);
        test_reset();
        rst_n = 1'b1;
        wait_clk(3);
        test_reset();
        test_idle_and_ack();
        test_start_stretch();
        test_after_stop();
        test_repeated_start();
        test_timeout();
        done = 1'b1;
        summary();
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end
endmodule